// File: doc/BRIEF.md
# Dual-Channel Simultaneous Sample Sequencer

This block is the digital control core of a four-input converter with a parallel host bus, running in its paired continuous mode. The host strobes chip-select, write and read without any relation to the system clock. The block brings these strobes into the system-clock domain and takes a six-bit configuration word on each write. It then counts read falling edges. On the first, third, fifth and later odd edges it holds the two preselected inputs together for one cycle. It converts the pair, first A and then B, using a digital stand-in for the conversion core.

Results come back through a two-slot output queue. The queue is reloaded only at the start of a read pair. The two reads of any pair therefore always return A and B of the same earlier sample instant, and a late conversion cannot split a pair. Sampling needs no start command: each odd read edge both starts a new conversion and hands the previous pair to the host.

An odd number of reads inside one chip-select window breaks the pairing. The block reports this through a sticky flag and restarts its pair counting.

Top module: `dualsamp_seq`

## Requirements
- R1: After reset, hold, conv_busy, rdata_oe, dual_mode, clk_ext, diff_sel and misalign are 0, pair_sel is 0 and rdata is 0.
- R2: A rising write strobe while chip-select is low loads the configuration word. Bits [3:2] = 2'b11 select paired mode (dual_mode = 1). Bit 5 selects the clock source (1 = external, 0 = internal oscillator). Bit 4 drives diff_sel and bits [1:0] drive pair_sel. The new values appear at most three clock cycles after the strobe edge.
- R3: In paired mode, hold is high for exactly one cycle on every odd-numbered read falling edge taken while chip-select is low. Counting restarts at each configuration write and at each chip-select deassertion. Even-numbered edges raise no hold.
- R4: conv_busy rises in the same cycle as hold. It stays high for 12 cycles when the internal source is selected and for 10 cycles when the external source is selected.
- R5: Within a chip-select window, read 2n-1 returns code A and read 2n returns code B of the pair sampled at the previous odd read edge. The first pair after reset returns 0 and 0.
- R6: Codes are captured at the hold. Code-input changes after the hold do not alter what is later read out.
- R7: rdata_oe is high only while the synchronized chip-select and read strobes are both low. rdata is 0 whenever rdata_oe is low.
- R8: Deasserting chip-select after an odd number of counted read edges sets misalign. misalign stays set until reset, and the next window starts again with an odd edge. An even count leaves misalign clear.
- R9: Outside paired mode, read strobes raise neither hold nor conv_busy and do not advance the pair count.
- R10: A clock-source change affects only conversions that start after the write that makes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip-select strobe, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| wdata | input | 6 | Configuration word taken on the write rising edge |
| code_a | input | 10 | Code the conversion stand-in returns for channel A |
| code_b | input | 10 | Code the conversion stand-in returns for channel B |
| rdata | output | 10 | Read data, 0 while not enabled |
| rdata_oe | output | 1 | Output-enable for the read data bus |
| hold | output | 1 | One-cycle simultaneous hold of both channels |
| conv_busy | output | 1 | A pair conversion is in progress |
| dual_mode | output | 1 | Paired continuous mode is active |
| clk_ext | output | 1 | External clock source selected |
| diff_sel | output | 1 | Differential input selection |
| pair_sel | output | 2 | Preselected channel pair |
| misalign | output | 1 | Sticky odd-read-count flag |

## Verification
The bench steers toward the cases where read-pair correlation can break. A design that reloaded the queue when a conversion finished, instead of at the odd edge, would mix B of one pair with A of the next. Code inputs are changed between the two reads of every pair to expose a design that samples late. A window is closed after a single read to check the sticky flag and the restart of counting; a design that kept the stale parity would then return B first. The clock source is switched between windows to confirm the busy length changes from 12 to 10 cycles. Read strobes are also issued outside paired mode and with chip-select high, to catch stray holds or a wrongly enabled bus.

// File: rtl/dualsamp_pkg.sv
package dualsamp_pkg;
  localparam int CODE_W = 10;
  localparam int CFG_W  = 6;

  typedef logic [CODE_W-1:0] code_t;

  // field layout follows the configuration word bit positions
  typedef struct packed {
    logic       clk_ext;   // bit 5
    logic       diff;      // bit 4
    logic [1:0] mode;      // bits 3:2
    logic [1:0] pair;      // bits 1:0
  } cfg_t;

  localparam logic [1:0] MODE_PAIRED = 2'b11;

  typedef struct packed {
    code_t b;
    code_t a;
  } pair_t;

  localparam int IDX_CS = 0;
  localparam int IDX_WR = 1;
  localparam int IDX_RD = 2;
  localparam int N_STROBES = 3;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_n,
  output logic [N-1:0] lvl,
  output logic [N-1:0] prev
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic meta_q, sync_q, last_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b1;
        sync_q <= 1'b1;
        last_q <= 1'b1;
      end else begin
        meta_q <= pin_n[i];
        sync_q <= meta_q;
        last_q <= sync_q;
      end
    end
    assign lvl[i]  = sync_q;
    assign prev[i] = last_q;
  end
endmodule

// File: rtl/conv_stub.sv
module conv_stub
  import dualsamp_pkg::*;
#(
  parameter int CYC_EXT = 10,
  parameter int CYC_INT = 12
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  logic  use_ext,
  input  code_t code_a,
  input  code_t code_b,
  output logic  busy,
  output pair_t result
);
  localparam int CYC_MAX = (CYC_EXT > CYC_INT) ? CYC_EXT : CYC_INT;
  localparam int CNT_W   = $clog2(CYC_MAX + 1);
  localparam logic [CNT_W-1:0] LOAD_EXT = CNT_W'(CYC_EXT - 1);
  localparam logic [CNT_W-1:0] LOAD_INT = CNT_W'(CYC_INT - 1);
  localparam logic [CNT_W-1:0] MID_EXT  = CNT_W'(CYC_EXT / 2);
  localparam logic [CNT_W-1:0] MID_INT  = CNT_W'(CYC_INT / 2);

  logic             active_q, active_d;
  logic             ext_q, ext_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  pair_t            cap_q, cap_d;
  pair_t            res_q, res_d;
  logic [CNT_W-1:0] mid;

  assign mid = ext_q ? MID_EXT : MID_INT;

  always_comb begin
    active_d = active_q;
    ext_d    = ext_q;
    cnt_d    = cnt_q;
    cap_d    = cap_q;
    res_d    = res_q;
    if (start) begin
      active_d = 1'b1;
      ext_d    = use_ext;
      cnt_d    = use_ext ? LOAD_EXT : LOAD_INT;
      cap_d.a  = code_a;
      cap_d.b  = code_b;
    end else if (active_q) begin
      if (cnt_q == '0) begin
        active_d = 1'b0;
        res_d.b  = cap_q.b;
      end else begin
        cnt_d = cnt_q - 1'b1;
        if (cnt_q == mid) res_d.a = cap_q.a;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      ext_q    <= 1'b0;
      cnt_q    <= '0;
      cap_q    <= '0;
      res_q    <= '0;
    end else begin
      active_q <= active_d;
      ext_q    <= ext_d;
      cnt_q    <= cnt_d;
      cap_q    <= cap_d;
      res_q    <= res_d;
    end
  end

  assign busy   = active_q;
  assign result = res_q;

  // R4
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> active_q);

  // R4
  busy_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && cnt_q == '0 && !start) |=> !active_q);
endmodule

// File: rtl/pair_queue.sv
module pair_queue
  import dualsamp_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  adv,
  input  logic  clr,
  input  pair_t din,
  output code_t dout
);
  localparam int SEL_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  code_t            slot_q [DEPTH];
  logic [SEL_W-1:0] sel_q, sel_d;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    code_t entry_in;
    assign entry_in = (i == 0) ? din.a : din.b;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    slot_q[i] <= '0;
      else if (load) slot_q[i] <= entry_in;
    end
  end

  always_comb begin
    sel_d = sel_q;
    if (load || clr) sel_d = '0;
    else if (adv)    sel_d = sel_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end

  assign dout = slot_q[sel_q];

  // R5
  sel_reset_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (sel_q == '0));
endmodule

// File: rtl/dualsamp_seq.sv
module dualsamp_seq
  import dualsamp_pkg::*;
#(
  parameter int CYC_EXT = 10,
  parameter int CYC_INT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic [CFG_W-1:0]  wdata,
  input  logic [CODE_W-1:0] code_a,
  input  logic [CODE_W-1:0] code_b,
  output logic [CODE_W-1:0] rdata,
  output logic              rdata_oe,
  output logic              hold,
  output logic              conv_busy,
  output logic              dual_mode,
  output logic              clk_ext,
  output logic              diff_sel,
  output logic [1:0]        pair_sel,
  output logic              misalign
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic [N_STROBES-1:0] strb_lvl, strb_prev;
  strobe_sync #(.N(N_STROBES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .pin_n ({rd_n, wr_n, cs_n}),
    .lvl   (strb_lvl),
    .prev  (strb_prev)
  );

  cfg_t  cfg_q, cfg_d;
  logic  odd_seen_q, odd_seen_d;
  logic  misalign_q, misalign_d;
  logic  hold_q;
  logic  paired;
  logic  cs_active, wr_rise, cs_rise, rd_fall, odd_ev, even_ev;
  pair_t conv_res;
  code_t q_out;
  logic  oe;

  assign paired    = (cfg_q.mode == MODE_PAIRED);
  assign cs_active = ~strb_lvl[IDX_CS];
  assign wr_rise   = ~strb_prev[IDX_WR] & strb_lvl[IDX_WR] & cs_active;
  assign cs_rise   = ~strb_prev[IDX_CS] & strb_lvl[IDX_CS];
  assign rd_fall   = strb_prev[IDX_RD] & ~strb_lvl[IDX_RD] & cs_active & paired;
  assign odd_ev    = rd_fall & ~odd_seen_q;
  assign even_ev   = rd_fall & odd_seen_q;

  always_comb begin
    cfg_d      = cfg_q;
    odd_seen_d = odd_seen_q;
    misalign_d = misalign_q;
    if (cs_rise) begin
      if (odd_seen_q) misalign_d = 1'b1;
      odd_seen_d = 1'b0;
    end else if (wr_rise) begin
      cfg_d      = cfg_t'(wdata);
      odd_seen_d = 1'b0;
    end else if (rd_fall) begin
      odd_seen_d = ~odd_seen_q;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cfg_q      <= '0;
      odd_seen_q <= 1'b0;
      misalign_q <= 1'b0;
      hold_q     <= 1'b0;
    end else begin
      cfg_q      <= cfg_d;
      odd_seen_q <= odd_seen_d;
      misalign_q <= misalign_d;
      hold_q     <= odd_ev;
    end
  end

  conv_stub #(.CYC_EXT(CYC_EXT), .CYC_INT(CYC_INT)) u_conv (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start   (odd_ev),
    .use_ext (cfg_q.clk_ext),
    .code_a  (code_a),
    .code_b  (code_b),
    .busy    (conv_busy),
    .result  (conv_res)
  );

  pair_queue #(.DEPTH(2)) u_queue (
    .clk   (clk),
    .rst_n (rst_int_n),
    .load  (odd_ev),
    .adv   (even_ev),
    .clr   (cs_rise),
    .din   (conv_res),
    .dout  (q_out)
  );

  assign oe        = cs_active & ~strb_lvl[IDX_RD];
  assign rdata_oe  = oe;
  assign rdata     = oe ? q_out : '0;
  assign hold      = hold_q;
  assign dual_mode = paired;
  assign clk_ext   = cfg_q.clk_ext;
  assign diff_sel  = cfg_q.diff;
  assign pair_sel  = cfg_q.pair;
  assign misalign  = misalign_q;

  // R3
  hold_single_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    hold_q |=> !hold_q);

  // R9
  hold_needs_paired_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    hold_q |-> $past(paired));

  // R8
  misalign_sticky_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    misalign_q |=> misalign_q);

  // R7
  bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !rdata_oe |-> (rdata == '0));

  // R4
  busy_with_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(conv_busy) |-> hold_q);
endmodule

// File: tb/dualsamp_seq_test.sv
module dualsamp_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
  logic [5:0] wdata = '0;
  logic [9:0] code_a = '0, code_b = '0;
  logic [9:0] rdata;
  logic       rdata_oe, hold, conv_busy, dual_mode, clk_ext, diff_sel, misalign;
  logic [1:0] pair_sel;

  dualsamp_seq uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .wdata(wdata), .code_a(code_a), .code_b(code_b), .rdata(rdata),
    .rdata_oe(rdata_oe), .hold(hold), .conv_busy(conv_busy),
    .dual_mode(dual_mode), .clk_ext(clk_ext), .diff_sel(diff_sel),
    .pair_sel(pair_sel), .misalign(misalign)
  );

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;
  bit mon_on = 1'b0;

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // ---------------- behavioural reference, stepped every clock ----------------
  bit m_dual = 0, m_ext = 0, m_par = 0, m_mis = 0, m_hold = 0, m_sel = 0;
  int m_busy = 0;
  int m_q0 = 0, m_q1 = 0, m_la = 0, m_lb = 0;
  bit c1 = 1, c2 = 1, c3 = 1, w1 = 1, w2 = 1, w3 = 1, r1 = 1, r2 = 1, r3 = 1;
  bit p_wr = 0, p_cs = 0, p_rd = 0;
  int hold_cnt = 0, busy_run = 0, last_busy_len = 0;

  task automatic step();
    bit eoe;
    int erd;
    m_hold = 0;
    if (m_busy > 0) m_busy--;
    if (p_cs) begin
      if (m_par) m_mis = 1;
      m_par = 0;
      m_sel = 0;
    end
    if (p_wr) begin
      m_dual = (wdata[3:2] == 2'b11);
      m_ext  = wdata[5];
      m_par  = 0;
    end
    if (p_rd) begin
      if (!m_par) begin
        m_hold = 1;
        m_busy = m_ext ? 10 : 12;
        m_q0 = m_la; m_q1 = m_lb;
        m_la = code_a; m_lb = code_b;
        m_sel = 0; m_par = 1;
      end else begin
        m_sel = 1; m_par = 0;
      end
    end
    c3 = c2; c2 = c1; c1 = cs_n;
    w3 = w2; w2 = w1; w1 = wr_n;
    r3 = r2; r2 = r1; r1 = rd_n;
    p_wr = !w3 && w2 && !c2;
    p_cs = !c3 && c2;
    p_rd = r3 && !r2 && !c2 && m_dual;
    eoe = !c2 && !r2;
    erd = eoe ? (m_sel ? m_q1 : m_q0) : 0;
    check("R3 hold", hold, m_hold);
    check("R4 conv_busy", conv_busy, m_busy > 0);
    check("R7 rdata_oe", rdata_oe, eoe);
    check("R5 rdata", rdata, erd);
    check("R2 dual_mode", dual_mode, m_dual);
    check("R2 clk_ext", clk_ext, m_ext);
    check("R8 misalign", misalign, m_mis);
    if (hold) hold_cnt++;
    if (conv_busy) busy_run++;
    else if (busy_run > 0) begin
      last_busy_len = busy_run;
      busy_run = 0;
    end
  endtask

  initial begin
    wait (mon_on);
    forever begin
      @(posedge clk);
      #2;
      step();
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cs_low();
    @(negedge clk) cs_n = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic cs_high();
    @(negedge clk) cs_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic write_cfg(input logic [5:0] v);
    @(negedge clk) wdata = v;
    @(negedge clk) wr_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic rd_strobe(output int seen);
    @(negedge clk) rd_n = 1'b0;
    repeat (5) @(negedge clk);
    seen = rdata;
    rd_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  // one read pair: expect the previous pair, present a new one at the hold
  task automatic read_pair(input int ea, input int eb, input int na, input int nb);
    int got;
    code_a = 10'(na);
    code_b = 10'(nb);
    rd_strobe(got);
    check("R5 first read returns A", got, ea);
    code_a = 10'h3AA;
    code_b = 10'h155;
    rd_strobe(got);
    check("R6 second read returns captured B", got, eb);
  endtask

  initial begin
    int got;
    int hold_before;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1
    check("R1 hold", hold, 0);
    check("R1 conv_busy", conv_busy, 0);
    check("R1 rdata_oe", rdata_oe, 0);
    check("R1 rdata", rdata, 0);
    check("R1 dual_mode", dual_mode, 0);
    check("R1 clk_ext", clk_ext, 0);
    check("R1 diff_sel", diff_sel, 0);
    check("R1 pair_sel", pair_sel, 0);
    check("R1 misalign", misalign, 0);
    mon_on = 1'b1;

    // R9: reads outside paired mode
    cs_low();
    code_a = 10'd50; code_b = 10'd60;
    rd_strobe(got);
    rd_strobe(got);
    cs_high();
    check("R9 no hold outside paired mode", hold_cnt, 0);
    check("R9 no busy outside paired mode", last_busy_len, 0);

    // R7: read with chip-select high
    @(negedge clk) rd_n = 1'b0;
    repeat (5) @(negedge clk);
    check("R7 bus disabled with cs high", rdata_oe, 0);
    check("R7 rdata zero with cs high", rdata, 0);
    rd_n = 1'b1;
    repeat (5) @(negedge clk);

    // window 1: internal clock
    cs_low();
    write_cfg(6'b001101);
    check("R2 dual_mode set", dual_mode, 1);
    check("R2 clk_ext internal", clk_ext, 0);
    check("R2 pair_sel", pair_sel, 1);
    check("R2 diff_sel", diff_sel, 0);
    hold_before = hold_cnt;
    read_pair(0, 0, 100, 200);
    check("R3 one hold per pair", hold_cnt - hold_before, 1);
    check("R4 busy length internal", last_busy_len, 12);
    read_pair(100, 200, 300, 400);
    check("R3 two holds for two pairs", hold_cnt - hold_before, 2);
    cs_high();
    check("R8 even count leaves flag clear", misalign, 0);

    // window 2: switch to external clock
    cs_low();
    write_cfg(6'b111100);
    check("R2 clk_ext external", clk_ext, 1);
    check("R2 diff_sel set", diff_sel, 1);
    read_pair(300, 400, 511, 1023);
    check("R10 busy length external", last_busy_len, 10);
    read_pair(511, 1023, 0, 5);
    cs_high();

    // R8: odd read count in a window
    cs_low();
    code_a = 10'd7; code_b = 10'd8;
    rd_strobe(got);
    check("R8 single read returns A", got, 0);
    cs_high();
    check("R8 flag set after odd count", misalign, 1);
    cs_low();
    read_pair(7, 8, 9, 10);
    cs_high();
    check("R8 flag sticky", misalign, 1);
    cs_low();
    read_pair(9, 10, 11, 12);
    cs_high();

    repeat (5) @(negedge clk);
    wrap_up();
  end

  initial begin
    #200000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    wrap_up();
  end
endmodule